// File: doc/BRIEF.md
# Sticky Error Status Controller

This block gathers seven internal error pulses from an audio signal path and keeps a record of them. The sources are overrange on the left and right converter channels and on the microphone converter, overflow on the left and right channels of the digital mixer, and overflow on the left and right channels of the effects engine. Software reaches three 16-bit registers through a simple synchronous register port. The first register enables each source. The second chooses which recorded errors raise an interrupt. The third holds the sticky status bits.

An enabled source sets its status bit on the cycle its error pulse arrives. The bit then stays set until software writes a 0 to that bit position. The block has two outputs. The first is a summary flag that a serial frame formatter places into its outgoing frame; it is the OR of every status bit and ignores the interrupt mask. The second is a registered interrupt request; it is raised only for status bits whose mask bit is set.

Top module: `err_sticky_ctrl`

## Requirements
- R1: After reset the enable, mask and status registers all read 0000h, and `err_flag` and `irq_req` are 0.
- R2: The enable register is at sub-address 9h, the mask register at Ah and the status register at Bh. All three share one bit layout: bit 8 left converter overrange, bit 9 right converter overrange, bit 10 microphone converter overrange, bit 12 left mixer overflow, bit 13 right mixer overflow, bit 14 left effects overflow, bit 15 right effects overflow. Bit 11 and bits 7..0 always read 0, so writing FFFFh to the enable or mask register reads back F700h.
- R3: On `err_in`, bit 0 is the left converter, bit 1 the right converter, bit 2 the microphone, bits 3 and 4 the left and right mixer, and bits 5 and 6 the left and right effects engine. A pulse from a source whose enable bit is 0 never sets its status bit.
- R4: A pulse from an enabled source sets its status bit at the next clock edge. The bit stays set after the pulse ends.
- R5: Writing 0 to a status bit clears it. Writing 1 to a status bit leaves it as it was.
- R6: If an enabled pulse and a write of 0 to the same status bit arrive in the same cycle, the bit ends up 1.
- R7: `err_flag` is 1 exactly when any status bit is 1, whatever the mask register holds.
- R8: `irq_req` is set at the clock edge after the one at which any status bit that has its mask bit set is 1. In other words, it is the registered OR of status AND mask.
- R9: Clearing an enable bit does not clear a status bit that is already set.
- R10: Reads of any sub-address other than 9h, Ah and Bh return 0000h. Writes to those sub-addresses change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register and error clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| reg_wr | input | 1 | Write strobe for one cycle |
| reg_addr | input | 4 | Register sub-address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr`, combinational |
| err_in | input | 7 | Single-cycle error pulses, one bit per source |
| err_flag | output | 1 | OR of all status bits |
| irq_req | output | 1 | Registered masked interrupt request |

## Verification
Several properties are checked on every cycle: reserved read bits are zero, a status bit rises only for an enabled pulse and falls only on a write of 0, set wins over clear, the summary flag matches the status, and the interrupt follows the masked status one cycle later. Other behaviour can only be shown by the bench's scenarios. This covers the exact bit positions of each source, the full set of enable and pulse patterns with varying masks, and the independence of the flag from the mask. It also covers enable changes that leave status alone and writes to unmapped sub-addresses.

// File: rtl/esc_pkg.sv
package esc_pkg;
  localparam int REG_W  = 16;
  localparam int N_SRC  = 7;
  localparam int ADDR_W = 4;
  localparam logic [ADDR_W-1:0] ADDR_CFG  = 4'h9;
  localparam logic [ADDR_W-1:0] ADDR_WAKE = 4'hA;
  localparam logic [ADDR_W-1:0] ADDR_STAT = 4'hB;

  // register bit that holds source i: three converter bits from 8, a gap at 11,
  // then four overflow bits from 12
  function automatic int src_pos(input int i);
    return (i < 3) ? 8 + i : 9 + i;
  endfunction

  function automatic logic [REG_W-1:0] src_to_reg(input logic [N_SRC-1:0] s);
    logic [REG_W-1:0] v;
    v = '0;
    for (int i = 0; i < N_SRC; i++) v[src_pos(i)] = s[i];
    return v;
  endfunction

  function automatic logic [N_SRC-1:0] reg_to_src(input logic [REG_W-1:0] r);
    logic [N_SRC-1:0] s;
    for (int i = 0; i < N_SRC; i++) s[i] = r[src_pos(i)];
    return s;
  endfunction
endpackage

// File: rtl/esc_mask_reg.sv
module esc_mask_reg #(
  parameter int W = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] q_r;
  logic [W-1:0] q_nxt;

  always_comb begin
    q_nxt = q_r;
    if (we) q_nxt = d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q_r <= '0;
    else if (we) q_r <= q_nxt;
  end

  assign q = q_r;
endmodule

// File: rtl/esc_sticky_bank.sv
module esc_sticky_bank #(
  parameter int N = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] stat_o
);
  for (genvar g = 0; g < N; g++) begin : g_bit
    logic q_r;
    logic q_nxt;
    logic en;

    // set dominates a simultaneous clear
    always_comb begin
      en    = set_i[g] | clr_i[g];
      q_nxt = set_i[g] | (q_r & ~clr_i[g]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q_r <= 1'b0;
      else if (en) q_r <= q_nxt;
    end

    assign stat_o[g] = q_r;
  end
endmodule

// File: rtl/esc_irq_gen.sv
module esc_irq_gen #(
  parameter int N = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] stat,
  input  logic [N-1:0] wake,
  output logic         flag,
  output logic         irq
);
  logic irq_r;
  logic irq_nxt;

  always_comb begin
    flag    = |stat;
    irq_nxt = |(stat & wake);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_r <= 1'b0;
    else        irq_r <= irq_nxt;
  end

  assign irq = irq_r;
endmodule

// File: rtl/err_sticky_ctrl.sv
module err_sticky_ctrl
  import esc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic [N_SRC-1:0]  err_in,
  output logic              err_flag,
  output logic              irq_req
);
  logic             wr_cfg, wr_wake, wr_stat;
  logic [N_SRC-1:0] wsrc;
  logic [N_SRC-1:0] cfg_q, wake_q, stat_q;
  logic [N_SRC-1:0] set_v, clr_v;

  always_comb begin
    wr_cfg  = reg_wr && (reg_addr == ADDR_CFG);
    wr_wake = reg_wr && (reg_addr == ADDR_WAKE);
    wr_stat = reg_wr && (reg_addr == ADDR_STAT);
    wsrc    = reg_to_src(reg_wdata);
    set_v   = err_in & cfg_q;
    clr_v   = wr_stat ? ~wsrc : '0;
  end

  esc_mask_reg #(.W(N_SRC)) u_cfg (
    .clk(clk), .rst_n(rst_n), .we(wr_cfg), .d(wsrc), .q(cfg_q)
  );

  esc_mask_reg #(.W(N_SRC)) u_wake (
    .clk(clk), .rst_n(rst_n), .we(wr_wake), .d(wsrc), .q(wake_q)
  );

  esc_sticky_bank #(.N(N_SRC)) u_stat (
    .clk(clk), .rst_n(rst_n), .set_i(set_v), .clr_i(clr_v), .stat_o(stat_q)
  );

  esc_irq_gen #(.N(N_SRC)) u_irq (
    .clk(clk), .rst_n(rst_n), .stat(stat_q), .wake(wake_q),
    .flag(err_flag), .irq(irq_req)
  );

  always_comb begin
    unique case (reg_addr)
      ADDR_CFG:  reg_rdata = src_to_reg(cfg_q);
      ADDR_WAKE: reg_rdata = src_to_reg(wake_q);
      ADDR_STAT: reg_rdata = src_to_reg(stat_q);
      default:   reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/esc_checker.sv
module esc_checker
  import esc_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [REG_W-1:0]  reg_wdata,
  input logic [REG_W-1:0]  reg_rdata,
  input logic [N_SRC-1:0]  err_in,
  input logic              err_flag,
  input logic              irq_req,
  input logic [N_SRC-1:0]  cfg_q,
  input logic [N_SRC-1:0]  wake_q,
  input logic [N_SRC-1:0]  stat_q
);
  localparam logic [REG_W-1:0] LIVE = src_to_reg('1);

  logic [N_SRC-1:0] ck_set;
  logic [N_SRC-1:0] ck_clr;
  always_comb begin
    ck_set = err_in & cfg_q;
    ck_clr = (reg_wr && reg_addr == ADDR_STAT) ? ~reg_to_src(reg_wdata) : '0;
  end

  p_rsvd_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata & ~LIVE) == '0);

  p_no_set_disabled_r3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((stat_q & ~$past(stat_q)) & ~$past(ck_set)) == '0);

  p_hold_until_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(stat_q) & ~stat_q) & ~$past(ck_clr)) == '0);

  p_set_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (stat_q & $past(ck_set)) == $past(ck_set));

  p_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag == (stat_q != '0));

  p_irq_r8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> irq_req == ($past(stat_q & wake_q) != '0));
endmodule

bind err_sticky_ctrl esc_checker u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .err_in(err_in),
  .err_flag(err_flag), .irq_req(irq_req),
  .cfg_q(cfg_q), .wake_q(wake_q), .stat_q(stat_q)
);

// File: tb/sim_err_sticky_ctrl.sv
module sim_err_sticky_ctrl;
  logic        clk;
  logic        rst_n;
  logic        reg_wr;
  logic [3:0]  reg_addr;
  logic [15:0] reg_wdata;
  logic [15:0] reg_rdata;
  logic [6:0]  err_in;
  logic        err_flag;
  logic        irq_req;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  err_sticky_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .err_in(err_in),
    .err_flag(err_flag), .irq_req(irq_req)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // bench-side layout from R2/R3: sources 0..2 -> bits 8..10, 3..6 -> bits 12..15
  function automatic logic [15:0] expand(input logic [6:0] s);
    logic [15:0] v = 16'h0000;
    for (int i = 0; i < 7; i++) v[(i < 3) ? 8 + i : 9 + i] = s[i];
    return v;
  endfunction

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  // one clock with given inputs, returns at the next falling edge with inputs idle
  task automatic step(input logic wr, input logic [3:0] a, input logic [15:0] d,
                      input logic [6:0] e);
    reg_wr = wr; reg_addr = a; reg_wdata = d; err_in = e;
    @(negedge clk);
    reg_wr = 1'b0; err_in = '0; reg_wdata = '0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] v);
    reg_addr = a;
    #0.5;
    v = reg_rdata;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    logic [6:0]  x, w;
    rst_n = 1'b0; reg_wr = 0; reg_addr = 0; reg_wdata = 0; err_in = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(4'h9, v); chk("R1 cfg", v, 16'h0000);
    rd(4'hA, v); chk("R1 wake", v, 16'h0000);
    rd(4'hB, v); chk("R1 stat", v, 16'h0000);
    chk("R1 flag", {15'b0, err_flag}, 16'h0);
    chk("R1 irq", {15'b0, irq_req}, 16'h0);

    // R2 reserved bits
    step(1, 4'h9, 16'hFFFF, 0); rd(4'h9, v); chk("R2 cfg", v, 16'hF700);
    step(1, 4'hA, 16'hFFFF, 0); rd(4'hA, v); chk("R2 wake", v, 16'hF700);

    // R10 unmapped address: write ignored, reads zero
    step(1, 4'h3, 16'hFFFF, 0);
    step(1, 4'hB, 16'hFFFF, 0);
    rd(4'h3, v); chk("R10 rd3", v, 16'h0000);
    rd(4'hF, v); chk("R10 rdF", v, 16'h0000);
    rd(4'hB, v); chk("R10/R5 stat", v, 16'h0000);
    step(1, 4'h3, 16'h0000, 0);
    rd(4'h9, v); chk("R10 cfg", v, 16'hF700);

    // R4 set and stick, R5 write-1 ignored, R5 write-0 clears
    step(0, 4'h0, 0, 7'h7F); step(0, 4'h0, 0, 0);
    rd(4'hB, v); chk("R4 sticky", v, 16'hF700);
    step(1, 4'hB, 16'hFFFF, 0); rd(4'hB, v); chk("R5 w1", v, 16'hF700);
    step(1, 4'hB, 16'hFEFF, 0); rd(4'hB, v); chk("R5 w0", v, 16'hF600);

    // R6 set wins: pulse left converter while clearing all
    step(1, 4'hB, 16'h0000, 7'h01); rd(4'hB, v); chk("R6 setwin", v, 16'h0100);

    // R9 clearing enable keeps status
    step(1, 4'h9, 16'h0000, 0); rd(4'hB, v); chk("R9 keep", v, 16'h0100);

    // R7 flag ignores mask; R8 irq masked
    step(1, 4'hA, 16'h0000, 0); step(0, 4'h0, 0, 0);
    chk("R7 flag", {15'b0, err_flag}, 16'h1);
    chk("R8 masked", {15'b0, irq_req}, 16'h0);
    step(1, 4'hA, 16'h0100, 0);
    chk("R8 lag", {15'b0, irq_req}, 16'h0);
    step(0, 4'h0, 0, 0);
    chk("R8 irq", {15'b0, irq_req}, 16'h1);

    // exhaustive sweep: every enable pattern x every pulse pattern (R3 R4 R7 R8)
    for (int c = 0; c < 128; c++) begin
      step(1, 4'h9, expand(7'(c)), 0);
      for (int e = 0; e < 128; e++) begin
        x = 7'(e) & 7'(c);
        w = 7'(e) ^ 7'(c) ^ 7'h5A;
        step(1, 4'hA, expand(w), 0);
        step(1, 4'hB, 16'h0000, 0);
        step(0, 4'h0, 0, 7'(e));
        rd(4'hB, v); chk("R3/R4 sweep stat", v, expand(x));
        chk("R7 sweep flag", {15'b0, err_flag}, {15'b0, (x != 0)});
        chk("R8 sweep irq0", {15'b0, irq_req}, 16'h0);
        step(0, 4'h0, 0, 0);
        chk("R8 sweep irq", {15'b0, irq_req}, {15'b0, ((x & w) != 0)});
      end
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule